// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral guards a system against software that stops responding. A down-counter runs from a programmable reload value. When it reaches zero the first time, a pending-interrupt flag is set and the count restarts from the reload value. If the count reaches zero again before software has acknowledged that interrupt, and the reset stage is enabled, a reset request is raised. The request stays high until the peripheral itself is reset.

Software reaches the block over a simple two-phase register bus with a setup cycle and an access cycle. To service the watchdog, software writes the acknowledge register. This clears the pending flag and restarts the count. A key register protects the configuration. Every write except one carrying the 32-bit key value closes the configuration registers to writes. Reads and counting continue normally while the registers are closed.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the reload register and the counter both read 0xFFFFFFFF, the control register reads 0, the key register reads 0 (open), the raw status reads 0, and both `irq` and `wdog_rst` are low.
- R2: A write to the reload register (offset 0x000) also copies the written value into the counter at once. The counter can be read at offset 0x004, and writes to that offset do nothing.
- R3: When control bit 0 is set, the counter decrements once per clock. One clock after the counter shows zero, it reloads and raw status bit 0 (offset 0x010) is set. With a reload value L, the first `irq` therefore appears L+1 clocks after the enabling write.
- R4: When the counter reaches zero while the raw flag is already set and control bit 1 is set, `wdog_rst` rises on that reload edge. With control bit 1 clear, no reset request is made.
- R5: Once raised, `wdog_rst` stays high until `rst_n` is asserted, even if the control register is cleared.
- R6: A write of any value to the acknowledge register (offset 0x00C) clears the raw flag and reloads the counter from the reload register.
- R7: The masked status register (offset 0x014) bit 0 equals raw status bit 0 AND control bit 0. `irq` follows the masked bit. The raw bit keeps its value when control bit 0 is cleared.
- R8: While control bit 0 is clear, the counter holds its value.
- R9: Writing 0x1ACCE551 to the key register (offset 0xC00) opens the configuration registers. Writing any other value closes them. Bit 0 of the key register reads 1 when the registers are closed and 0 when they are open.
- R10: While the registers are closed, writes to the reload, control and acknowledge registers are ignored. Reads still return the current values, and an enabled counter keeps running.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq | output | 1 | Level interrupt, equal to the masked status bit |
| wdog_rst | output | 1 | Sticky reset request |

## Verification
The hardest condition to reach is the second-stage reset. It needs a first expiry to be left unacknowledged and then a full second count with the reset stage enabled. The bench produces it with a reload value of 3, so `wdog_rst` is expected on exactly the eighth edge after the enabling write; the bench samples the cycle before and the cycle after. The opposite case, where the counter never expires, is driven by acknowledging every few cycles across several hundred clocks. The closed-register case runs a live counter while writes are attempted, so the bench can show that the counter kept moving even though the writes took no effect.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq,
  output logic              wdog_rst
);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(12'hC00);
  localparam logic [31:0]       KEY    = 32'h1ACCE551;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic [1:0]       ctrl_q;
  logic             ris_q, unlocked;

  logic wr_en, wr_ok, wr_load, wr_ctrl, wr_ack, wr_key, expire;

  assign wr_en   = psel & penable & pwrite;
  assign wr_ok   = wr_en & unlocked;
  assign wr_load = wr_ok & (paddr == A_LOAD);
  assign wr_ctrl = wr_ok & (paddr == A_CTRL);
  assign wr_ack  = wr_ok & (paddr == A_ACK);
  assign wr_key  = wr_en & (paddr == A_KEY);
  assign expire  = ctrl_q[0] & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '1;
      cnt_q    <= '1;
      ctrl_q   <= 2'b00;
      ris_q    <= 1'b0;
      unlocked <= 1'b1;
      wdog_rst <= 1'b0;
    end else begin
      if (wr_key)  unlocked <= (pwdata == KEY);
      if (wr_ctrl) ctrl_q   <= pwdata[1:0];
      if (wr_load) begin
        load_q <= pwdata[CNT_W-1:0];
        cnt_q  <= pwdata[CNT_W-1:0];
      end else if (wr_ack) begin
        cnt_q <= load_q;
        ris_q <= 1'b0;
      end else if (expire) begin
        cnt_q <= load_q;
        ris_q <= 1'b1;
        if (ris_q && ctrl_q[1]) wdog_rst <= 1'b1;
      end else if (ctrl_q[0]) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign irq = ris_q & ctrl_q[0];

  always_comb begin
    prdata = '0;
    unique case (paddr)
      A_LOAD:  prdata = 32'(load_q);
      A_CNT:   prdata = 32'(cnt_q);
      A_CTRL:  prdata = {30'b0, ctrl_q};
      A_RAW:   prdata = {31'b0, ris_q};
      A_MSK:   prdata = {31'b0, irq};
      A_KEY:   prdata = {31'b0, ~unlocked};
      default: prdata = '0;
    endcase
  end
endmodule

module wdog_twostage_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] paddr,
  input logic              unlocked,
  input logic [1:0]        ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic              ris_q,
  input logic              wdog_rst
);
  a_r3_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && cnt_q == '0 && !wr_en) |=> (cnt_q == $past(load_q) && ris_q));

  a_r4_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> ($past(ris_q) && $past(ctrl_q[1])));

  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> wdog_rst);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked && paddr == ADDR_W'(12'h00C)) |=> (!ris_q && cnt_q == $past(load_q)));

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !wr_en) |=> $stable(cnt_q));

  a_r10_locked_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && paddr == ADDR_W'(12'h000)) |=> $stable(load_q));
endmodule

bind wdog_twostage wdog_twostage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .paddr(paddr), .unlocked(unlocked),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .load_q(load_q), .ris_q(ris_q), .wdog_rst(wdog_rst)
);

// File: tb/wdog_twostage_test.sv
`timescale 1ns/1ps
module wdog_twostage_test;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_ACK = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014, A_KEY = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 0, rst_n = 0, psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic irq, wdog_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_twostage uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
                     .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .wdog_rst(wdog_rst));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    bus_rd(A_LOAD, v); chk("R1 load", v, 32'hFFFFFFFF);
    bus_rd(A_CNT, v);  chk("R1 count", v, 32'hFFFFFFFF);
    bus_rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    bus_rd(A_KEY, v);  chk("R1 key", v, 0);
    bus_rd(A_RAW, v);  chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", wdog_rst, 0);
  endtask

  task automatic t_load_copy();
    logic [31:0] v;
    do_reset();
    bus_wr(A_LOAD, 32'd77);
    bus_rd(A_CNT, v); chk("R2 count copy", v, 77);
    bus_wr(A_CNT, 32'd5);
    bus_rd(A_CNT, v); chk("R2 count read-only", v, 77);
    bus_rd(A_LOAD, v); chk("R2 load readback", v, 77);
  endtask

  task automatic t_expiry();
    logic [31:0] v, w;
    do_reset();
    bus_wr(A_LOAD, 32'd4);
    bus_wr(A_CTRL, 32'd1);
    repeat (4) @(negedge clk);
    chk("R3 irq before first expiry", irq, 0);
    @(negedge clk);
    chk("R3 irq at first expiry", irq, 1);
    repeat (5) @(negedge clk);
    chk("R4 no reset when stage off", wdog_rst, 0);
    chk("R3 irq still pending", irq, 1);
    bus_wr(A_CTRL, 32'd0);
    chk("R7 irq masked off", irq, 0);
    bus_rd(A_RAW, v); chk("R7 raw kept", v, 1);
    bus_rd(A_MSK, v); chk("R7 masked zero", v, 0);
    bus_rd(A_CNT, v); bus_rd(A_CNT, w);
    chk("R8 counter holds", w, v);
    bus_wr(A_ACK, 32'd0);
    bus_rd(A_RAW, v); chk("R6 raw cleared", v, 0);
    bus_rd(A_CNT, v); chk("R6 counter reloaded", v, 4);
  endtask

  task automatic t_second_stage();
    do_reset();
    bus_wr(A_LOAD, 32'd3);
    bus_wr(A_CTRL, 32'd3);
    repeat (7) @(negedge clk);
    chk("R4 no reset before second expiry", wdog_rst, 0);
    @(negedge clk);
    chk("R4 reset on second expiry", wdog_rst, 1);
    bus_wr(A_CTRL, 32'd0);
    repeat (20) @(negedge clk);
    chk("R5 reset sticky", wdog_rst, 1);
    do_reset();
    chk("R5 reset cleared by rst_n", wdog_rst, 0);
  endtask

  task automatic t_ping();
    logic [31:0] v;
    do_reset();
    bus_wr(A_LOAD, 32'd20);
    bus_wr(A_CTRL, 32'd3);
    for (int i = 0; i < 30; i++) begin
      repeat (8) @(negedge clk);
      bus_wr(A_ACK, 32'd1);
    end
    chk("R6 ping keeps reset low", wdog_rst, 0);
    chk("R6 ping keeps irq low", irq, 0);
    bus_rd(A_RAW, v); chk("R6 ping raw clear", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v, w;
    do_reset();
    bus_wr(A_LOAD, 32'd4);
    bus_wr(A_CTRL, 32'd1);
    repeat (8) @(negedge clk);
    bus_wr(A_LOAD, 32'd1000);
    bus_wr(A_KEY, 32'h00000001);
    bus_rd(A_KEY, v); chk("R9 key reads closed", v, 1);
    bus_wr(A_ACK, 32'd0);
    bus_rd(A_RAW, v); chk("R10 ack ignored when closed", v, 1);
    bus_wr(A_LOAD, 32'd5);
    bus_rd(A_LOAD, v); chk("R10 load ignored when closed", v, 1000);
    bus_wr(A_CTRL, 32'd0);
    bus_rd(A_CTRL, v); chk("R10 ctrl ignored when closed", v, 1);
    bus_rd(A_CNT, v); bus_rd(A_CNT, w);
    chk("R10 counter runs when closed", (v - w), 3);
    bus_wr(A_KEY, 32'h12345678);
    bus_rd(A_KEY, v); chk("R9 wrong key stays closed", v, 1);
    bus_wr(A_KEY, KEY);
    bus_rd(A_KEY, v); chk("R9 key opens", v, 0);
    bus_wr(A_CTRL, 32'd0);
    bus_rd(A_CTRL, v); chk("R9 ctrl writable after open", v, 0);
  endtask

  initial begin
    t_reset_state();
    t_load_copy();
    t_expiry();
    t_second_stage();
    t_ping();
    t_lock();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule